// File: doc/BRIEF.md
# eSPI Agent Link-Layer Lane Shifter

This block is the agent-side link layer of an eSPI slave, running entirely in the eSPI clock domain. During the command phase it samples the data pins and assembles incoming bits into bytes for the transaction layer. After a fixed turnaround it enters the response phase, drives the pins, and serializes response fields that the transaction layer hands over one multibyte field at a time. It handles one, two or four active lanes and owns the per-lane output enables that control the pad tri-states.

Each response field carries its own kind. Header fields such as length and address leave the block most significant byte first. Data and status fields leave least significant byte first. Within a byte, bits always leave most significant bit first. The transaction layer starts a response by pulsing a request once the command has been decoded. Deasserting chip-select abandons whatever is in flight and returns the block to command receive.

Top module: `espi_lane_shifter`

## Requirements
- R1: Single-lane mode (`cfg_width` 00): command bits are taken from lane 0 only, one per clock, and response bits are driven on lane 1 only, with `pin_oe` = 4'b0010 in the response phase.
- R2: While the block is in the command phase, `pin_oe` is 4'b0000 on every lane, so lane 1 stays tri-stated and the host may drive it.
- R3: Dual-lane mode (`cfg_width` 01): two bits move per clock in both phases, lane 1 carrying the earlier (higher) bit of each pair, with `pin_oe` = 4'b0011 in the response phase.
- R4: Quad-lane mode (`cfg_width` 10): four bits move per clock, lane 3 carrying the highest bit of each nibble, with `pin_oe` = 4'b1111 in the response phase.
- R5: `rx_valid` is high for exactly one clock, with `rx_byte` holding the assembled byte (first received bit in bit 7), in the cycle after the clock edge that sampled the byte's last bits.
- R6: A field with `tx_kind` 00 (header) of N bytes, taken from the low N bytes of `tx_word`, is sent most significant byte first.
- R7: A field with `tx_kind` 01 (data) or 10 (status), and also 11, is sent least significant byte first.
- R8: After `rsp_start` is sampled high in the command phase, `pin_oe` stays 0 for exactly two clocks; in the next clock it goes to the mode mask together with the first response bits.
- R9: One clock after `cs_n` is sampled high, `pin_oe` is 0, `rx_valid` and `tx_ready` are 0, partly assembled bits are dropped, and any unsent field is discarded.
- R10: The lane width is taken from `cfg_width` only while `cs_n` is high; changes while `cs_n` is low have no effect. Code 11 selects single-lane mode.
- R11: `tx_ready` is high only while `cs_n` is low and no bytes of an accepted field remain. A field is taken when `tx_valid` and `tx_ready` are both high at a clock edge. A following field presented in time is sent with no gap.
- R12: While `rst` is high, `pin_oe` is 0 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | eSPI clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| cfg_width | input | 2 | Lane width code: 00 single, 01 dual, 10 quad, 11 single |
| rsp_start | input | 1 | Pulse from the transaction layer that ends the command phase |
| pin_in | input | 4 | Sampled data-pin levels, lane 0 in bit 0 |
| pin_out | output | 4 | Registered data-pin drive values |
| pin_oe | output | 4 | Registered per-lane output enables |
| rx_byte | output | 8 | Last assembled command byte |
| rx_valid | output | 1 | One-clock strobe for `rx_byte` |
| tx_word | input | 32 | Response field value, byte 0 in bits 7:0 |
| tx_nbm1 | input | 2 | Field length in bytes minus one |
| tx_kind | input | 2 | Field kind: 00 header, 01 data, 10 status |
| tx_valid | input | 1 | Field offered |
| tx_ready | output | 1 | Field can be taken |

## Verification
The bench targets the lane ordering in each width. A design that swapped lanes within a pair or nibble would return bit-reversed command bytes and scrambled response bytes. It targets byte order per field kind, which a single fixed ordering would fail for either headers or data, and the two-clock turnaround, where an enable raised one clock early or late would show at the ports in those cycles. It also breaks a command off mid-byte and flips `cfg_width` while chip-select is low. A design that kept stale bit counts would then deliver a shifted byte, and one that followed the configuration pin mid-transaction would change bit rate. A quad-mode run with two fields back to back exposes any idle gap between fields as corrupted bytes.

// File: rtl/espi_shift_pkg.sv
package espi_shift_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    W_ONE  = 2'd0,
    W_TWO  = 2'd1,
    W_FOUR = 2'd2
  } lane_mode_t;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_TAR = 2'd1,
    PH_RSP = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    FK_HDR  = 2'd0,
    FK_DATA = 2'd1,
    FK_STAT = 2'd2
  } field_kind_t;

  function automatic lane_mode_t decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    return W_TWO;
      2'd2:    return W_FOUR;
      default: return W_ONE;
    endcase
  endfunction

  function automatic logic [LANES-1:0] oe_mask(input lane_mode_t m);
    case (m)
      W_TWO:   return 4'b0011;
      W_FOUR:  return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic [3:0] bits_per_clk(input lane_mode_t m);
    case (m)
      W_TWO:   return 4'd2;
      W_FOUR:  return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/espi_phase_ctl.sv
module espi_phase_ctl
  import espi_shift_pkg::*;
#(
  parameter int TAR_CYCLES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   rsp_start,
  input  logic [1:0]             cfg_width,
  output lane_mode_t             mode_q,
  output phase_t                 phase_q,
  output logic                   ser_run,
  output logic [LANES-1:0]       oe_q
);

  localparam int TW = (TAR_CYCLES > 1) ? $clog2(TAR_CYCLES) : 1;

  logic [TW-1:0] tar_q;
  logic          tar_last;

  assign tar_last = (tar_q == TW'(TAR_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= W_ONE;
      phase_q <= PH_CMD;
      tar_q   <= '0;
      oe_q    <= '0;
    end else if (cs_n) begin
      mode_q  <= decode_mode(cfg_width);
      phase_q <= PH_CMD;
      tar_q   <= '0;
      oe_q    <= '0;
    end else begin
      case (phase_q)
        PH_CMD: begin
          if (rsp_start) begin
            phase_q <= PH_TAR;
            tar_q   <= '0;
          end
        end
        PH_TAR: begin
          if (tar_last) begin
            phase_q <= PH_RSP;
            oe_q    <= oe_mask(mode_q);
          end else begin
            tar_q <= tar_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // The serializer loads its first byte on the edge that leaves turnaround.
  assign ser_run = !cs_n && ((phase_q == PH_TAR && tar_last) || phase_q == PH_RSP);

endmodule

// File: rtl/espi_rx_deser.sv
module espi_rx_deser
  import espi_shift_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  phase_t             phase,
  input  lane_mode_t         mode,
  input  logic [LANES-1:0]   pins,
  output logic [BYTE_W-1:0]  byte_q,
  output logic               valid_q
);

  logic [BYTE_W-1:0] sh_q, sh_nx;
  logic [3:0]        cnt_q, cnt_nx;

  always_comb begin
    case (mode)
      W_TWO:   sh_nx = {sh_q[BYTE_W-3:0], pins[1:0]};
      W_FOUR:  sh_nx = {sh_q[BYTE_W-5:0], pins[3:0]};
      default: sh_nx = {sh_q[BYTE_W-2:0], pins[0]};
    endcase
    cnt_nx = cnt_q + bits_per_clk(mode);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else if (cs_n || phase != PH_CMD) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_nx;
      valid_q <= 1'b0;
      if (cnt_nx == 4'(BYTE_W)) begin
        byte_q  <= sh_nx;
        valid_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/espi_tx_order.sv
module espi_tx_order
  import espi_shift_pkg::*;
#(
  parameter int FIELD_BYTES = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cs_n,
  input  logic [BYTE_W*FIELD_BYTES-1:0]     word,
  input  logic [$clog2(FIELD_BYTES)-1:0]    nbm1,
  input  logic [1:0]                        kind,
  input  logic                              valid,
  output logic                              ready,
  input  logic                              take,
  output logic [BYTE_W-1:0]                 cur,
  output logic                              avail
);

  localparam int IW = $clog2(FIELD_BYTES);

  logic [BYTE_W*FIELD_BYTES-1:0] word_q;
  logic [IW-1:0]                 idx_q;
  logic [IW:0]                   rem_q;
  logic                          msb_first_q;

  assign ready = !cs_n && (rem_q == '0);
  assign avail = (rem_q != '0);
  assign cur   = word_q[{idx_q, 3'b000} +: BYTE_W];

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      word_q      <= '0;
      idx_q       <= '0;
      rem_q       <= '0;
      msb_first_q <= 1'b0;
    end else if (valid && ready) begin
      word_q      <= word;
      rem_q       <= {1'b0, nbm1} + 1'b1;
      msb_first_q <= (kind == FK_HDR);
      idx_q       <= (kind == FK_HDR) ? nbm1 : '0;
    end else if (take) begin
      rem_q <= rem_q - 1'b1;
      idx_q <= msb_first_q ? idx_q - 1'b1 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/espi_tx_ser.sv
module espi_tx_ser
  import espi_shift_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  lane_mode_t         mode,
  input  logic [BYTE_W-1:0]  byte_in,
  input  logic               avail,
  output logic               take,
  output logic [LANES-1:0]   out_q
);

  logic [BYTE_W-1:0] sh_q, src;
  logic [3:0]        cnt_q, step;
  logic [LANES-1:0]  slice;

  assign step = bits_per_clk(mode);
  assign take = run && (cnt_q == '0) && avail;
  assign src  = (cnt_q == '0) ? byte_in : sh_q;

  always_comb begin
    case (mode)
      W_TWO:   slice = {2'b00, src[7:6]};
      W_FOUR:  slice = src[7:4];
      default: slice = {2'b00, src[7], 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sh_q  <= '0;
      cnt_q <= '0;
      out_q <= '0;
    end else if (cnt_q == '0 && !avail) begin
      out_q <= '1;
    end else begin
      out_q <= slice;
      sh_q  <= src << step;
      cnt_q <= ((cnt_q == '0) ? 4'(BYTE_W) : cnt_q) - step;
    end
  end

endmodule

// File: rtl/espi_lane_shifter.sv
module espi_lane_shifter
  import espi_shift_pkg::*;
#(
  parameter int FIELD_BYTES = 4,
  parameter int TAR_CYCLES  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cs_n,
  input  logic [1:0]                     cfg_width,
  input  logic                           rsp_start,
  input  logic [3:0]                     pin_in,
  output logic [3:0]                     pin_out,
  output logic [3:0]                     pin_oe,
  output logic [7:0]                     rx_byte,
  output logic                           rx_valid,
  input  logic [8*FIELD_BYTES-1:0]       tx_word,
  input  logic [$clog2(FIELD_BYTES)-1:0] tx_nbm1,
  input  logic [1:0]                     tx_kind,
  input  logic                           tx_valid,
  output logic                           tx_ready
);

  lane_mode_t        mode_w;
  phase_t            phase_w;
  logic              run_w;
  logic              take_w;
  logic              avail_w;
  logic [BYTE_W-1:0] cur_w;

  espi_phase_ctl #(.TAR_CYCLES(TAR_CYCLES)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rsp_start (rsp_start),
    .cfg_width (cfg_width),
    .mode_q    (mode_w),
    .phase_q   (phase_w),
    .ser_run   (run_w),
    .oe_q      (pin_oe)
  );

  espi_rx_deser u_rx (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .phase   (phase_w),
    .mode    (mode_w),
    .pins    (pin_in),
    .byte_q  (rx_byte),
    .valid_q (rx_valid)
  );

  espi_tx_order #(.FIELD_BYTES(FIELD_BYTES)) u_order (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n),
    .word  (tx_word),
    .nbm1  (tx_nbm1),
    .kind  (tx_kind),
    .valid (tx_valid),
    .ready (tx_ready),
    .take  (take_w),
    .cur   (cur_w),
    .avail (avail_w)
  );

  espi_tx_ser u_ser (
    .clk     (clk),
    .rst     (rst),
    .run     (run_w),
    .mode    (mode_w),
    .byte_in (cur_w),
    .avail   (avail_w),
    .take    (take_w),
    .out_q   (pin_out)
  );

endmodule

// File: rtl/espi_lane_shifter_chk.sv
module espi_lane_shifter_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rx_valid,
  input logic       tx_ready,
  input logic [3:0] pin_oe,
  input logic [1:0] phase,
  input logic [1:0] mode
);

  // R2
  cmd_oe_low_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0) |-> (pin_oe == 4'b0000));

  // R1
  single_lane0_in_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> !pin_oe[0]);

  // R4
  oe_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_oe != 4'b0000) |->
      (pin_oe == ((mode == 2'd2) ? 4'b1111 : (mode == 2'd1) ? 4'b0011 : 4'b0010)));

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8
  turnaround_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && $past(phase) != 2'd2) |->
      ($past(phase, 1) == 2'd1 && $past(phase, 2) == 2'd1));

  // R9
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (pin_oe == 4'b0000 && !rx_valid));

  // R11
  ready_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !cs_n);

  // R10
  width_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> $stable(mode));

endmodule

bind espi_lane_shifter espi_lane_shifter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .rx_valid (rx_valid),
  .tx_ready (tx_ready),
  .pin_oe   (pin_oe),
  .phase    (phase_w),
  .mode     (mode_w)
);

// File: tb/tb_espi_lane_shifter.sv
`timescale 1ns/1ps
module tb_espi_lane_shifter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        rsp_start = 1'b0;
  logic        tx_valid = 1'b0;
  logic [1:0]  cfg_width = 2'd0;
  logic [1:0]  tx_nbm1 = 2'd0;
  logic [1:0]  tx_kind = 2'd0;
  logic [3:0]  pin_in = 4'd0;
  logic [31:0] tx_word = 32'd0;
  wire  [3:0]  pin_out, pin_oe;
  wire  [7:0]  rx_byte;
  wire         rx_valid, tx_ready;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] f_word [4];
  logic [1:0]  f_nbm1 [4];
  logic [1:0]  f_kind [4];
  int          feed_cnt = 0;
  int          feed_idx = 0;
  bit          rdy_prev = 1'b0;
  logic [7:0]  exp_b [16];
  logic [1:0]  exp_k [16];
  int          exp_n;

  // mode[45:44] cmd[43:36] word[35:4] nbm1[3:2] kind[1:0]
  localparam logic [45:0] VEC [7] = '{
    {2'd0, 8'hA5, 32'h11223344, 2'd3, 2'd0},
    {2'd1, 8'h3C, 32'hCAFEF00D, 2'd3, 2'd1},
    {2'd2, 8'h96, 32'h0000BEEF, 2'd1, 2'd2},
    {2'd2, 8'h5A, 32'h00ABCDEF, 2'd2, 2'd0},
    {2'd0, 8'h81, 32'h000000C3, 2'd0, 2'd1},
    {2'd1, 8'h7E, 32'h00001234, 2'd1, 2'd0},
    {2'd3, 8'hE1, 32'h000055AA, 2'd1, 2'd1}
  };

  espi_lane_shifter dut (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .cfg_width (cfg_width),
    .rsp_start (rsp_start),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .tx_word   (tx_word),
    .tx_nbm1   (tx_nbm1),
    .tx_kind   (tx_kind),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int lanes(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic [3:0] mask_of(input logic [1:0] m);
    return (m == 2'd1) ? 4'b0011 : (m == 2'd2) ? 4'b1111 : 4'b0010;
  endfunction

  function automatic string mtag(input logic [1:0] m);
    return (m == 2'd1) ? "R3" : (m == 2'd2) ? "R4" : "R1";
  endfunction

  // Field feeder: offers queued fields and advances after each accepted handshake (R11).
  initial forever begin
    @(negedge clk);
    #1;
    if (tx_valid && rdy_prev) feed_idx++;
    tx_valid = (feed_idx < feed_cnt);
    if (feed_idx < 4) begin
      tx_word = f_word[feed_idx];
      tx_nbm1 = f_nbm1[feed_idx];
      tx_kind = f_kind[feed_idx];
    end
    rdy_prev = tx_ready;
  end

  task automatic run_txn(input logic [1:0] mode, input logic [7:0] cmd, input int nf, input string rxtag);
    int w;
    logic [3:0] m;
    bit oe_bad, early_v;
    logic [7:0] acc;
    int nbits, bi, nb;
    w = lanes(mode);
    m = mask_of(mode);
    oe_bad = 1'b0;
    early_v = 1'b0;
    exp_n = 0;
    for (int f = 0; f < nf; f++) begin
      nb = int'(f_nbm1[f]) + 1;
      for (int j = 0; j < nb; j++) begin
        exp_b[exp_n] = (f_kind[f] == 2'd0) ? f_word[f][8*(nb-1-j) +: 8] : f_word[f][8*j +: 8];
        exp_k[exp_n] = f_kind[f];
        exp_n++;
      end
    end
    @(negedge clk);
    cs_n = 1'b1; cfg_width = mode; feed_cnt = 0; feed_idx = 0; rdy_prev = 1'b0; pin_in = 4'd0;
    repeat (2) @(negedge clk);
    // R10: flip the width code while selected; the latched width must hold
    cs_n = 1'b0;
    cfg_width = (mode == 2'd2) ? 2'd0 : 2'd2;
    feed_cnt = nf;
    for (int k = 0; k < 8 / w; k++) begin
      if (k > 0) @(negedge clk);
      if (k > 0 && rx_valid) early_v = 1'b1;
      if (pin_oe != 4'd0) oe_bad = 1'b1;
      case (w)
        1: pin_in = {3'b101, cmd[7-k]};
        2: pin_in = {2'b10, cmd[7-2*k -: 2]};
        default: pin_in = cmd[7-4*k -: 4];
      endcase
    end
    @(negedge clk);
    chk(rx_valid === 1'b1 && rx_byte === cmd, rxtag, {23'd0, rx_valid, rx_byte}, {23'd0, 1'b1, cmd});
    chk(!early_v, "R5 no early strobe", 32'(early_v), 32'd0);
    chk(!oe_bad && pin_oe == 4'd0, "R2 enables low in command phase", {28'd0, pin_oe}, 32'd0);
    rsp_start = 1'b1;
    pin_in = 4'd0;
    @(negedge clk);
    rsp_start = 1'b0;
    chk(pin_oe == 4'd0 && !rx_valid, "R8/R5 turnaround clock 1", {27'd0, rx_valid, pin_oe}, 32'd0);
    @(negedge clk);
    chk(pin_oe == 4'd0, "R8 turnaround clock 2", {28'd0, pin_oe}, 32'd0);
    @(negedge clk);
    chk(pin_oe == m, {mtag(mode), " R8 enables rise with response"}, {28'd0, pin_oe}, {28'd0, m});
    nbits = 0;
    bi = 0;
    acc = 8'd0;
    oe_bad = 1'b0;
    for (int c = 0; c < exp_n * 8 / w; c++) begin
      if (c > 0) @(negedge clk);
      if (pin_oe != m) oe_bad = 1'b1;
      case (w)
        1: acc = {acc[6:0], pin_out[1]};
        2: acc = {acc[5:0], pin_out[1:0]};
        default: acc = {acc[3:0], pin_out[3:0]};
      endcase
      nbits += w;
      if (nbits == 8) begin
        chk(acc === exp_b[bi],
            (exp_k[bi] == 2'd0) ? "R6 header byte order" : "R7 data/status byte order",
            {24'd0, acc}, {24'd0, exp_b[bi]});
        bi++;
        nbits = 0;
      end
    end
    chk(!oe_bad, {mtag(mode), " enables held through response"}, 32'(oe_bad), 32'd0);
    cs_n = 1'b1;
    @(negedge clk);
    chk(pin_oe == 4'd0 && !tx_ready && !rx_valid, "R9 deselect clears outputs",
        {26'd0, tx_ready, rx_valid, pin_oe}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(pin_oe == 4'd0 && !rx_valid, "R12 reset state", {27'd0, rx_valid, pin_oe}, 32'd0);
    chk(!tx_ready, "R11 not ready while deselected", 32'(tx_ready), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // table of vectors, one field per transaction
    for (int v = 0; v < 7; v++) begin
      f_word[0] = VEC[v][35:4];
      f_nbm1[0] = VEC[v][3:2];
      f_kind[0] = VEC[v][1:0];
      run_txn(VEC[v][45:44], VEC[v][43:36], 1,
              (VEC[v][45:44] == 2'd3) ? "R10 code 11 acts as single lane" :
              {mtag(VEC[v][45:44]), " command byte"});
    end

    // R11: two fields back to back in quad mode, no gap between them
    f_word[0] = 32'h0000A1B2; f_nbm1[0] = 2'd1; f_kind[0] = 2'd0;
    f_word[1] = 32'h00C3D4E5; f_nbm1[1] = 2'd2; f_kind[1] = 2'd1;
    run_txn(2'd2, 8'hC7, 2, "R11 R4 command before two fields");

    // R9: abort mid-byte, then a clean byte must assemble from scratch
    @(negedge clk);
    cs_n = 1'b1; cfg_width = 2'd0;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    pin_in = 4'b0001;
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(!rx_valid && pin_oe == 4'd0, "R9 abort gives no strobe", {27'd0, rx_valid, pin_oe}, 32'd0);
    f_word[0] = 32'h0000005E; f_nbm1[0] = 2'd0; f_kind[0] = 2'd2;
    run_txn(2'd0, 8'h0F, 1, "R9 bit count cleared by deselect");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule